// File: doc/BRIEF.md
# Debug Monitor Entry and Security Handshake Controller

This block settles, at the moment the internal reset is released, whether a microcontroller boots into its serial debug monitor and which clock source that monitor runs from. The decision combines three things: whether the reset vector is still blank, the level seen on the interrupt pin (low, high, or raised to the high test voltage), and a pair of strap pins. The result is frozen at reset release and holds until the next reset, whatever the pins do afterwards.

Once the monitor is active, the block runs the opening exchange over a single-wire serial link. The host sends a fixed number of security bytes. Each one is compared with a stored key, and the block keeps receiving until the full count has arrived, even after a mismatch. The block then drives a long break on its transmit line and raises a ready flag for the command layer that sits above it. The bit timing comes from a clock-enable tick. Its divisor follows the selected clock source, so the link keeps the same baud rate with either clock.

Top module: `dbgmon_entry`

## Requirements
- R1: The reset vector counts as erased only when `vec_hi` and `vec_lo` are both 8'hFF. With a programmed vector, the monitor is entered only when `irq_level` is 2'b10 (test voltage), and `clk_int_sel` is then 0 (external clock).
- R2: With an erased vector and `irq_level` 2'b01 (logic high), the monitor is entered with `clk_int_sel` = 0.
- R3: With an erased vector and `irq_level` 2'b00 (logic low), the monitor is entered with `clk_int_sel` = 1. The baud tick then uses the internal-clock divisor `INT_DIV` in place of `EXT_DIV`.
- R4: Entry also requires `mode_sel` to equal `MODE_KEY`. `irq_level` 2'b11 never enters. When entry fails, `monitor_active` = 0 and `clk_int_sel` = 0.
- R5: The pins are sampled at every clock edge while `rst_n` is low. The values from the last edge before `rst_n` rises are held. Changes on `irq_level`, `mode_sel` or the vector bytes after that edge leave `monitor_active` and `clk_int_sel` unchanged.
- R6: A serial frame is one low start bit, 8 data bits sent least significant bit first, and one high stop bit. The line idles high. One bit lasts `OVS` ticks, and a tick comes every `EXT_DIV` or `INT_DIV` clocks, depending on the clock source.
- R7: Exactly `NUM_SEC` (8) valid frames are taken as security bytes. A frame whose stop bit is low is dropped and not counted. Before the last byte, `cmd_ready` stays 0 and `txd` stays 1.
- R8: After the last security byte, `security_ok` is 1 only if byte i matched key byte i for every i (key byte i is `SEC_KEY[8*i+7:8*i]`). A mismatch does not stop reception.
- R9: After the last security byte, `txd` is held low for `BRK_BITS` (10) bit times. It then returns high and `cmd_ready` becomes 1.
- R10: When the monitor is not entered, `txd` stays 1 and `security_ok` and `cmd_ready` stay 0 until the next reset, whatever arrives on `rxd`.
- R11: Right after reset release, `security_ok` = 0, `cmd_ready` = 0 and `txd` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Internal reset, active low; its release freezes the entry decision |
| irq_level | input | 2 | Interrupt pin level: 00 low, 01 high, 10 test voltage, 11 invalid |
| vec_hi | input | 8 | Reset-vector byte at the highest address |
| vec_lo | input | 8 | Reset-vector byte at the next address down |
| mode_sel | input | 2 | Strap pins that must equal MODE_KEY for entry |
| rxd | input | 1 | Serial receive line from the host |
| monitor_active | output | 1 | Monitor mode latched |
| clk_int_sel | output | 1 | 1 = internal oscillator, 0 = external clock |
| security_ok | output | 1 | All security bytes matched the key |
| cmd_ready | output | 1 | Break sent, ready for commands |
| txd | output | 1 | Serial transmit line to the host |

## Verification
The assertions check on every cycle that the latched mode and clock choice never move between resets, and that the internal clock is never chosen without monitor entry. They also check that the transmit line stays high and both status flags stay low while the monitor is off, that the byte count never passes its limit, that a received-byte strobe lasts one cycle, and that `cmd_ready` rises only at the end of a low break. Only the bench scenarios can show the rest: the full entry truth table over vector, IRQ level and strap pins; that a bad-stop frame is not counted; that one wrong key byte clears `security_ok` while the handshake still completes; and that the break lasts ten bit times at each clock's divisor.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;

   typedef enum logic [1:0] {
      IRQ_LOW  = 2'b00,
      IRQ_HIGH = 2'b01,
      IRQ_TEST = 2'b10,
      IRQ_BAD  = 2'b11
   } irq_lvl_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAIT
   } rx_st_e;

   typedef enum logic [1:0] {
      HS_SEC,
      HS_BRK,
      HS_RDY
   } hs_st_e;

   localparam logic [7:0] VEC_BLANK = 8'hFF;

endpackage

// File: rtl/dbgmon_mode_latch.sv
module dbgmon_mode_latch
   import dbgmon_pkg::*;
#(
   parameter logic [1:0] MODE_KEY = 2'b10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] irq_level,
   input  logic [7:0] vec_hi,
   input  logic [7:0] vec_lo,
   input  logic [1:0] mode_sel,
   output logic       active,
   output logic       int_sel
);

   irq_lvl_e irq;
   logic     blank;
   logic     strap_ok;
   logic     enter;
   logic     use_int;
   logic     act_q;
   logic     int_q;

   always_comb begin
      irq      = irq_lvl_e'(irq_level);
      blank    = (vec_hi == VEC_BLANK) && (vec_lo == VEC_BLANK);
      strap_ok = (mode_sel == MODE_KEY);
      enter    = strap_ok &&
                 ((irq == IRQ_TEST) ||
                  (blank && ((irq == IRQ_HIGH) || (irq == IRQ_LOW))));
      use_int  = enter && blank && (irq == IRQ_LOW);
   end

   // Track pins while reset is held; freeze once it is released.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= enter;
         int_q <= use_int;
      end
   end

   assign active  = act_q;
   assign int_sel = int_q;

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(act_q) && $stable(int_q))); // R5

   AST_INT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> act_q); // R4

endmodule

// File: rtl/dbgmon_baud_gen.sv
module dbgmon_baud_gen #(
   parameter int EXT_DIV = 64,
   parameter int INT_DIV = 83
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sel_int,
   output logic tick
);

   localparam int MAXD = (EXT_DIV > INT_DIV) ? EXT_DIV : INT_DIV;
   localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

   generate
      if (EXT_DIV < 1 || INT_DIV < 1) begin : g_bad_div
         $error("dbgmon_baud_gen: divisors must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim = sel_int ? CW'(INT_DIV - 1) : CW'(EXT_DIV - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q == lim) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

   AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) && en |-> cnt_q <= lim); // R6

endmodule

// File: rtl/dbgmon_uart_rx.sv
module dbgmon_uart_rx
   import dbgmon_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rxd,
   output logic       byte_valid,
   output logic [7:0] byte_data
);

   localparam int OW = $clog2(OVS);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("dbgmon_uart_rx: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("dbgmon_uart_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic rxs;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd;
         end
         assign rxs = s_q;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '1;
            else        ch_q <= {ch_q[SYNC_STAGES-2:0], rxd};
         end
         assign rxs = ch_q[SYNC_STAGES-1];
      end
   endgenerate

   rx_st_e        st_q;
   logic [OW-1:0] ocnt_q;
   logic [2:0]    bidx_q;
   logic [7:0]    sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         ocnt_q     <= '0;
         bidx_q     <= '0;
         sh_q       <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (!en) begin
            st_q <= RX_IDLE;
         end else if (tick) begin
            case (st_q)
               RX_IDLE: begin
                  if (!rxs) begin
                     st_q   <= RX_START;
                     ocnt_q <= '0;
                  end
               end
               RX_START: begin
                  if (ocnt_q == OW'(OVS/2 - 1)) begin
                     ocnt_q <= '0;
                     bidx_q <= '0;
                     st_q   <= rxs ? RX_IDLE : RX_DATA;
                  end else begin
                     ocnt_q <= ocnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (ocnt_q == OW'(OVS - 1)) begin
                     ocnt_q <= '0;
                     sh_q   <= {rxs, sh_q[7:1]};
                     bidx_q <= bidx_q + 1'b1;
                     if (bidx_q == 3'd7) st_q <= RX_STOP;
                  end else begin
                     ocnt_q <= ocnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (ocnt_q == OW'(OVS - 1)) begin
                     ocnt_q <= '0;
                     if (rxs) begin
                        byte_valid <= 1'b1;
                        st_q       <= RX_IDLE;
                     end else begin
                        st_q <= RX_WAIT;
                     end
                  end else begin
                     ocnt_q <= ocnt_q + 1'b1;
                  end
               end
               RX_WAIT: begin
                  if (rxs) st_q <= RX_IDLE;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign byte_data = sh_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid); // R6

endmodule

// File: rtl/dbgmon_handshake.sv
module dbgmon_handshake
   import dbgmon_pkg::*;
#(
   parameter int                 NUM_SEC  = 8,
   parameter int                 BRK_BITS = 10,
   parameter int                 OVS      = 16,
   parameter logic [NUM_SEC*8-1:0] SEC_KEY = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       byte_valid,
   input  logic [7:0] byte_data,
   output logic       security_ok,
   output logic       cmd_ready,
   output logic       txd
);

   localparam int CNTW      = $clog2(NUM_SEC + 1);
   localparam int BRK_TICKS = BRK_BITS * OVS;
   localparam int BW        = $clog2(BRK_TICKS + 1);

   generate
      if (NUM_SEC < 1 || BRK_BITS < 1) begin : g_bad_cfg
         $error("dbgmon_handshake: NUM_SEC and BRK_BITS must be at least 1");
      end
   endgenerate

   logic [7:0] key_arr [NUM_SEC];

   generate
      for (genvar k = 0; k < NUM_SEC; k++) begin : g_key
         assign key_arr[k] = SEC_KEY[k*8 +: 8];
      end
   endgenerate

   hs_st_e          st_q;
   logic [CNTW-1:0] cnt_q;
   logic [BW-1:0]   brk_q;
   logic            match_q;
   logic            ok_q;
   logic [7:0]      key_sel;
   logic            match_nxt;

   always_comb begin
      key_sel = '0;
      for (int k = 0; k < NUM_SEC; k++) begin
         if (cnt_q == CNTW'(k)) key_sel = key_arr[k];
      end
      match_nxt = match_q && (byte_data == key_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= HS_SEC;
         cnt_q   <= '0;
         brk_q   <= '0;
         match_q <= 1'b1;
         ok_q    <= 1'b0;
      end else if (en) begin
         case (st_q)
            HS_SEC: begin
               if (byte_valid) begin
                  match_q <= match_nxt;
                  cnt_q   <= cnt_q + 1'b1;
                  if (cnt_q == CNTW'(NUM_SEC - 1)) begin
                     ok_q  <= match_nxt;
                     brk_q <= '0;
                     st_q  <= HS_BRK;
                  end
               end
            end
            HS_BRK: begin
               if (tick) begin
                  if (brk_q == BW'(BRK_TICKS - 1)) st_q <= HS_RDY;
                  else                             brk_q <= brk_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign security_ok = ok_q;
   assign cmd_ready   = (st_q == HS_RDY);
   assign txd         = (st_q != HS_BRK);

   AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNTW'(NUM_SEC)); // R7

   AST_OK_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> cnt_q == CNTW'(NUM_SEC)); // R8

   AST_READY_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> $past(txd) == 1'b0); // R9

endmodule

// File: rtl/dbgmon_entry.sv
module dbgmon_entry
   import dbgmon_pkg::*;
#(
   parameter int                   NUM_SEC     = 8,
   parameter int                   BRK_BITS    = 10,
   parameter int                   OVS         = 16,
   parameter int                   EXT_DIV     = 64,
   parameter int                   INT_DIV     = 83,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [1:0]           MODE_KEY    = 2'b10,
   parameter logic [NUM_SEC*8-1:0] SEC_KEY     = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] irq_level,
   input  logic [7:0] vec_hi,
   input  logic [7:0] vec_lo,
   input  logic [1:0] mode_sel,
   input  logic       rxd,
   output logic       monitor_active,
   output logic       clk_int_sel,
   output logic       security_ok,
   output logic       cmd_ready,
   output logic       txd
);

   logic       tick;
   logic       byte_valid;
   logic [7:0] byte_data;

   dbgmon_mode_latch #(
      .MODE_KEY (MODE_KEY)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_level (irq_level),
      .vec_hi    (vec_hi),
      .vec_lo    (vec_lo),
      .mode_sel  (mode_sel),
      .active    (monitor_active),
      .int_sel   (clk_int_sel)
   );

   dbgmon_baud_gen #(
      .EXT_DIV (EXT_DIV),
      .INT_DIV (INT_DIV)
   ) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (monitor_active),
      .sel_int (clk_int_sel),
      .tick    (tick)
   );

   dbgmon_uart_rx #(
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (monitor_active),
      .tick       (tick),
      .rxd        (rxd),
      .byte_valid (byte_valid),
      .byte_data  (byte_data)
   );

   dbgmon_handshake #(
      .NUM_SEC  (NUM_SEC),
      .BRK_BITS (BRK_BITS),
      .OVS      (OVS),
      .SEC_KEY  (SEC_KEY)
   ) u_hs (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (monitor_active),
      .tick        (tick),
      .byte_valid  (byte_valid),
      .byte_data   (byte_data),
      .security_ok (security_ok),
      .cmd_ready   (cmd_ready),
      .txd         (txd)
   );

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !monitor_active |-> (txd && !cmd_ready && !security_ok)); // R10

endmodule

// File: tb/tb_dbgmon_entry.sv
module tb_dbgmon_entry;

   localparam int         OVS     = 8;
   localparam int         EXT_DIV = 2;
   localparam int         INT_DIV = 3;
   localparam int         NSEC    = 8;
   localparam int         BRKB    = 10;
   localparam logic [1:0] MKEY    = 2'b10;
   localparam logic [63:0] KEY    = 64'h8877_6655_4433_2211;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] irq_level;
   logic [7:0] vec_hi, vec_lo;
   logic [1:0] mode_sel;
   logic       rxd;
   logic       monitor_active, clk_int_sel, security_ok, cmd_ready, txd;

   int checks = 0;
   int fails  = 0;
   int lo_cnt = 0;
   logic meas_clr = 1'b1;

   always #5 clk = ~clk;

   dbgmon_entry #(
      .NUM_SEC (NSEC), .BRK_BITS (BRKB), .OVS (OVS),
      .EXT_DIV (EXT_DIV), .INT_DIV (INT_DIV), .SYNC_STAGES (2),
      .MODE_KEY (MKEY), .SEC_KEY (KEY)
   ) dut (
      .clk (clk), .rst_n (rst_n), .irq_level (irq_level),
      .vec_hi (vec_hi), .vec_lo (vec_lo), .mode_sel (mode_sel),
      .rxd (rxd), .monitor_active (monitor_active),
      .clk_int_sel (clk_int_sel), .security_ok (security_ok),
      .cmd_ready (cmd_ready), .txd (txd)
   );

   always @(posedge clk) begin
      if (meas_clr)  lo_cnt <= 0;
      else if (!txd) lo_cnt <= lo_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] irq, input logic [1:0] ms,
                           input logic [7:0] hi, input logic [7:0] lo);
      @(negedge clk);
      rst_n = 1'b0; rxd = 1'b1; meas_clr = 1'b1;
      irq_level = irq; mode_sel = ms; vec_hi = hi; vec_lo = lo;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      meas_clr = 1'b0;
   endtask

   function automatic logic [7:0] key_byte(input int i);
      return 8'((i + 1) * 8'h11);
   endfunction

   task automatic send_byte(input logic [7:0] b, input int bc, input bit good_stop);
      rxd = 1'b0;
      cyc(bc);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         cyc(bc);
      end
      rxd = good_stop;
      cyc(bc);
      rxd = 1'b1;
      cyc(bc);
   endtask

   task automatic send_key(input int bc, input int bad_idx, input int count);
      for (int i = 0; i < count; i++) begin
         logic [7:0] b;
         b = key_byte(i);
         if (i == bad_idx) b = b ^ 8'h40;
         send_byte(b, bc, 1'b1);
      end
   endtask

   task automatic wait_ready(input int limit);
      for (int t = 0; t < limit && !cmd_ready; t++) cyc(1);
   endtask

   task automatic chk_break(input int div, input string req);
      int n;
      n = BRKB * OVS;
      chk(lo_cnt >= (n - 1) * div + 1 && lo_cnt <= n * div, req, lo_cnt, n * div);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rxd = 1'b1; irq_level = 2'b00; mode_sel = 2'b00;
      vec_hi = 8'h00; vec_lo = 8'h00;

      // Entry truth-table sweep (R1..R5, R11)
      for (int v = 0; v < 3; v++) begin
         for (int irq = 0; irq < 4; irq++) begin
            for (int ms = 0; ms < 4; ms++) begin
               logic [7:0] hi, lo;
               bit blank, e_act, e_int;
               hi = (v == 2) ? 8'h3C : 8'hFF;
               lo = (v == 1) ? 8'h3C : 8'hFF;
               blank = (v == 0);
               e_act = (2'(ms) == MKEY) && ((irq == 2) || (blank && irq <= 1));
               e_int = e_act && blank && (irq == 0);
               do_reset(2'(irq), 2'(ms), hi, lo);
               chk(monitor_active == e_act, "R1 R2 R4 entry", monitor_active, e_act);
               chk(clk_int_sel == e_int, "R3 clock select", clk_int_sel, e_int);
               chk(txd && !cmd_ready && !security_ok, "R11 reset outputs",
                   {txd, cmd_ready, security_ok}, 3'b100);
               irq_level = ~2'(irq); mode_sel = ~2'(ms); vec_hi = 8'h00; vec_lo = 8'h00;
               cyc(3);
               chk(monitor_active == e_act && clk_int_sel == e_int, "R5 latched mode held",
                   {monitor_active, clk_int_sel}, {e_act, e_int});
            end
         end
      end

      // Scenario A: erased vector, IRQ high, external clock, bad frame inserted
      do_reset(2'b01, MKEY, 8'hFF, 8'hFF);
      send_key(OVS * EXT_DIV, -1, 3);
      send_byte(8'h5A, OVS * EXT_DIV, 1'b0);
      rxd = 1'b1;
      cyc(2 * OVS * EXT_DIV);
      for (int i = 3; i < 7; i++) send_byte(key_byte(i), OVS * EXT_DIV, 1'b1);
      chk(!cmd_ready && txd && !security_ok, "R7 bad frame not counted",
          {cmd_ready, txd, security_ok}, 3'b010);
      send_byte(key_byte(7), OVS * EXT_DIV, 1'b1);
      wait_ready(5000);
      chk(cmd_ready, "R9 ready after break", cmd_ready, 1);
      chk(txd, "R9 txd high after break", txd, 1);
      chk(security_ok, "R8 all bytes match", security_ok, 1);
      chk_break(EXT_DIV, "R9 R6 break length ext");

      // Scenario B: erased vector, IRQ low, internal clock, one wrong byte
      do_reset(2'b00, MKEY, 8'hFF, 8'hFF);
      send_key(OVS * INT_DIV, 2, NSEC);
      wait_ready(5000);
      chk(cmd_ready, "R8 handshake completes after mismatch", cmd_ready, 1);
      chk(!security_ok, "R8 mismatch clears ok", security_ok, 0);
      chk_break(INT_DIV, "R3 R9 break length int");

      // Scenario C: programmed vector, test voltage, external clock
      do_reset(2'b10, MKEY, 8'h12, 8'h34);
      chk(monitor_active && !clk_int_sel, "R1 test-voltage entry",
          {monitor_active, clk_int_sel}, 2'b10);
      send_key(OVS * EXT_DIV, -1, NSEC);
      wait_ready(5000);
      chk(cmd_ready && security_ok, "R8 R1 programmed entry handshake",
          {cmd_ready, security_ok}, 2'b11);
      chk_break(EXT_DIV, "R9 break length test entry");

      // Scenario D: no entry, bytes arrive anyway
      do_reset(2'b01, MKEY, 8'h12, 8'h34);
      send_key(OVS * EXT_DIV, -1, NSEC);
      cyc(2000);
      chk(lo_cnt == 0, "R10 txd stays high", lo_cnt, 0);
      chk(!cmd_ready && !security_ok, "R10 flags stay low",
          {cmd_ready, security_ok}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule